// File: doc/BRIEF.md
# Addressable Actuator Output Controller

This block connects a small processor to seven actuator control lines: the air-conditioning compressor, four door locks, the engine starter and the windshield wipers. The processor puts a 4-bit command code on a bus and pulses a single strobe. On each rising clock edge where the strobe is high, the block decodes the code and either sets or clears one stored control bit. Every output comes straight from a flip-flop, so it keeps its value after the strobe is gone.

The most significant code bit chooses the action: 0 turns a device on and 1 turns it off. The lower three bits choose the device. Device index 7 does nothing in either polarity, so codes 7 and 15 are no-ops.

Top module: `act_ctrl`

## Requirements
- R1: A synchronous active-high reset `rst` clears all seven bits of `act_q`.
- R2: While `io_en` is sampled low, `act_q` does not change, whatever the value on `addr`.
- R3: With `io_en` high, codes 0 to 6 (`addr[3]`=0) set `act_q[addr[2:0]]` on that clock edge. The bit order of `act_q` is: bit0 compressor, bit1..bit4 door locks 0..3, bit5 engine starter, bit6 wipers.
- R4: With `io_en` high, codes 8 to 14 (`addr[3]`=1) clear `act_q[addr[2:0]]` on that clock edge.
- R5: A command changes only the bit it selects. All other bits keep their values.
- R6: Codes 7 and 15 leave `act_q` unchanged, even when the strobe is high.
- R7: A bit that has been set stays set through any number of idle cycles, until a clear command for it arrives or reset is applied.
- R8: Setting a bit that is already set, or clearing a bit that is already clear, leaves `act_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| io_en | input | 1 | Command strobe, sampled on the clock edge |
| addr | input | 4 | Command code: bit3 selects off, bits 2..0 select the device |
| act_q | output | 7 | Registered actuator control bits |

## Verification
The bench first runs the address-then-strobe sequence 2, 1, 3 and checks that only door locks 0 to 2 turn on. It then sweeps every code with the strobe low. A design that decoded without gating on the strobe would switch devices here. Both no-op codes are sent with the strobe high. A decoder that let index 7 wrap around, or let it touch any real bit, would corrupt a neighbouring device. Repeated sets and clears, clears of bits that are already off, and long idle gaps check that a command affects one bit only and that set state persists; a design that cleared the whole bank or toggled bits would fail these checks.

// File: rtl/act_ctrl.sv
module act_ctrl #(
  parameter int ADDR_W = 4,
  parameter int N_ACT  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_ACT-1:0]  act_q
);
  localparam int SEL_W = ADDR_W - 1;

  logic [SEL_W-1:0] sel;
  logic             off_cmd;
  logic [N_ACT-1:0] hit;

  assign sel     = addr[SEL_W-1:0];
  assign off_cmd = addr[ADDR_W-1];

  always_comb begin
    hit = '0;
    for (int i = 0; i < N_ACT; i++)
      hit[i] = io_en && (int'(sel) == i);
  end

  always_ff @(posedge clk) begin
    if (rst)          act_q <= '0;
    else if (off_cmd) act_q <= act_q & ~hit;
    else              act_q <= act_q | hit;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> act_q == '0); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !io_en |=> $stable(act_q)); // R2
  AST_SET_BIT: assert property (@(posedge clk) disable iff (rst)
    (io_en && !addr[ADDR_W-1] && int'(addr[SEL_W-1:0]) < N_ACT)
      |=> act_q[$past(addr[SEL_W-1:0])]); // R3
  AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (rst)
    (io_en && addr[ADDR_W-1] && int'(addr[SEL_W-1:0]) < N_ACT)
      |=> !act_q[$past(addr[SEL_W-1:0])]); // R4
  AST_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    io_en |=> $countones(act_q ^ $past(act_q)) <= 1); // R5
  AST_NOOP: assert property (@(posedge clk) disable iff (rst)
    (io_en && int'(addr[SEL_W-1:0]) >= N_ACT) |=> $stable(act_q)); // R6
endmodule

// File: tb/act_ctrl_bench.sv
module act_ctrl_bench;
  logic clk = 0, rst = 1, io_en = 0;
  logic [3:0] addr = '0;
  logic [6:0] act_q;
  int n_chk = 0, n_bad = 0;
  logic [6:0] model = '0;
  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  act_ctrl u_act_ctrl (.clk(clk), .rst(rst), .io_en(io_en), .addr(addr), .act_q(act_q));

  task automatic chk(input logic [6:0] exp, input string tag);
    n_chk++;
    if (act_q !== exp) begin
      n_bad++;
      $display("FAIL %s act_q=%b exp=%b", tag, act_q, exp);
    end
  endtask

  // Driver: change the address, wait one clock, then pulse the strobe for one clock.
  task automatic cmd(input logic [3:0] a, input string tag);
    @(negedge clk); addr = a; io_en = 0;
    @(negedge clk); io_en = 1;
    if (a[2:0] != 3'd7) begin
      if (a[3]) model[a[2:0]] = 1'b0; else model[a[2:0]] = 1'b1;
    end
    exp_q.push_back(model); tag_q.push_back(tag);
    @(negedge clk); io_en = 0;
  endtask

  // Monitor: compare one clock edge after the strobe was sampled high.
  always @(posedge clk) begin
    if (!rst && io_en) begin
      @(negedge clk);
      if (exp_q.size() > 0) chk(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act_q=%b exp=done", act_q);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(7'b0, "R1 reset");
    cmd(4'd2, "R3 seq door1");
    cmd(4'd1, "R3 seq door0");
    cmd(4'd3, "R3 seq door2");
    chk(7'b0001110, "R3 seq result");
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); addr = 4'(a); io_en = 0;
    end
    @(negedge clk);
    chk(model, "R2 strobe low sweep");
    cmd(4'd7, "R6 code7");
    cmd(4'd0, "R3 compressor");
    cmd(4'd4, "R3 door3");
    cmd(4'd5, "R3 starter");
    cmd(4'd6, "R3 wipers");
    cmd(4'd15, "R6 code15");
    chk(7'b1111111, "R3 all on");
    cmd(4'd5, "R8 set again");
    repeat (50) @(negedge clk);
    chk(7'b1111111, "R7 persist");
    cmd(4'd9, "R4 clear door0");
    cmd(4'd8, "R4 clear compressor");
    cmd(4'd14, "R4 clear wipers");
    cmd(4'd14, "R8 clear again");
    chk(7'b0111100, "R5 only selected bits");
    cmd(4'd15, "R6 code15 again");
    cmd(4'd2, "R8 set again door1");
    cmd(4'd10, "R4 clear door1");
    cmd(4'd0, "R3 compressor again");
    chk(7'b0111001, "R5 final");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk(7'b0, "R1 reset mid-run");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule